// File: doc/BRIEF.md
# Pin Change-of-State Wake and Interrupt Detector

This block watches a set of external input pins (30 by default) and raises a sticky interrupt request when a pin that software has enabled changes level. It keeps one snapshot of the pin levels. While the clock runs, the snapshot follows a two-stage synchronized copy of the pins. When the clock is about to be gated for sleep, the snapshot is frozen. A purely combinational compare of the raw pins against the frozen snapshot then drives a wake request that needs no clock edge. When the clock returns, that wake request passes through a synchronizer and is latched as the interrupt.

Each pin also has a weak pull-up control bit. These bits are kept apart from the interrupt enables. A per-pin direction input forces the pull-up output low for any pin that is driven as an output. Software reaches the two enable words and the two pull-up words over a simple register bus. Writing to a fifth address clears the interrupt.

The controller is a four-state machine. **RUN** is normal tracking. The transition *go_to_sleep* (sleep_req high) enters **PARK**, where the snapshot is frozen. The transition *clock_back* (sleep_req low) enters **RESYNC_A**. The transition *sync_wait* moves unconditionally to **RESYNC_B**. The transition *resume* returns to RUN. On that last edge the synchronized wake request is latched into the interrupt and the snapshot is reloaded.

Top module: `cos_wake_detector`

## Requirements
- R1: After reset all enable and pull-up bits are 0, irq is 0, wake_req is 0 and every pullup_en bit is 0.
- R2: The enable bits for pins 0..15 are at address 0 and those for pins 16..29 at address 1 (pin 16 in bit 0). The pull-up bits use the same layout at addresses 2 and 3. Bits that map to no pin (bits 14 and 15 of addresses 1 and 3) read as 0. bus_rdata is a combinational read of the word at bus_addr, and other addresses read 0.
- R3: In RUN, when an enabled pin changes level, irq rises on the third rising clock edge after the change.
- R4: A pin whose enable bit is 0 never sets irq and never raises wake_req.
- R5: irq stays 1 until a bus write to address 4, whatever the data. If a change is detected on the same edge as that write, irq stays 1.
- R6: pullup_en[i] is 1 exactly when pull-up bit i is 1 and pin_dir[i] is 0 (pin_dir 1 marks a digital output).
- R7: sleep_req sampled high in RUN moves the block to PARK on that edge. In PARK the snapshot is frozen and no pin change sets irq, however many edges pass.
- R8: wake_req is 0 in RUN. In the other states it is 1 whenever the raw level of an enabled pin differs from the snapshot, with no clock edge needed.
- R9: sleep_req sampled low in PARK leads to RESYNC_A, then RESYNC_B, then RUN on consecutive edges. irq sets on the edge that leaves RESYNC_B if a wake request was pending before the wake-up. A change that reverted before the wake-up is not reported, and a reported change is not reported a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (gated off during sleep) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | High requests parking before the clock stops; low after the clock returns |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 30 | Raw external pin levels |
| pin_dir | input | 30 | Per-pin direction, 1 = output |
| irq | output | 1 | Sticky interrupt request |
| wake_req | output | 1 | Asynchronous wake request while parked |
| pullup_en | output | 30 | Weak pull-up enables after direction gating |

## Verification
The assertions rely on the system sequencing sleep_req as a handshake. It is raised only while the clock still runs. It is lowered only once the clock is back. It is not raised again before the machine is back in RUN. The checks also assume pins stay still from the moment sleep_req falls until RUN is reached, because changes in that two-edge resume window fall between the wake path and the snapshot reload. The stimulus drives every input one time unit after a rising edge. It changes pins only when the block is in RUN or PARK. It holds each pin level for at least three edges before requesting sleep, so the snapshot is settled when it freezes.

// File: rtl/cos_pkg.sv
package cos_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_PARK     = 2'd1,
        ST_RESYNC_A = 2'd2,
        ST_RESYNC_B = 2'd3
    } cos_state_e;

endpackage

// File: rtl/cos_sync_chain.sv
module cos_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cos_regfile.sv
module cos_regfile #(
    parameter int NUM_PINS = 30,
    parameter int REG_W    = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_dir,
    output logic [NUM_PINS-1:0] en_vec,
    output logic [NUM_PINS-1:0] pullup_en,
    output logic                clr_flag
);

    localparam int REG_CNT  = (NUM_PINS + REG_W - 1) / REG_W;
    localparam int CLR_ADDR = 2 * REG_CNT;

    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] pu_q;

    for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
        localparam int WORD = b / REG_W;
        localparam int POS  = b % REG_W;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[b] <= 1'b0;
                pu_q[b] <= 1'b0;
            end else if (bus_wr) begin
                if (bus_addr == ADDR_W'(WORD)) begin
                    en_q[b] <= bus_wdata[POS];
                end
                if (bus_addr == ADDR_W'(REG_CNT + WORD)) begin
                    pu_q[b] <= bus_wdata[POS];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_PINS; b++) begin
            if (bus_addr == ADDR_W'(b / REG_W)) begin
                bus_rdata[b % REG_W] = en_q[b];
            end
            if (bus_addr == ADDR_W'(REG_CNT + b / REG_W)) begin
                bus_rdata[b % REG_W] = pu_q[b];
            end
        end
    end

    assign en_vec    = en_q;
    assign pullup_en = pu_q & ~pin_dir;
    assign clr_flag  = bus_wr && (bus_addr == ADDR_W'(CLR_ADDR));

endmodule

// File: rtl/cos_ctrl.sv
module cos_ctrl
    import cos_pkg::*;
#(
    parameter int NUM_PINS = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] pin_view,
    input  logic [NUM_PINS-1:0] en_vec,
    input  logic                clr_flag,
    input  logic                wake_seen,
    output logic                irq,
    output logic                wake_req,
    output cos_state_e          state_o
);

    cos_state_e          state_q;
    cos_state_e          state_d;
    logic [NUM_PINS-1:0] snap_q;
    logic                flag_q;
    logic                run_hit;
    logic                set_flag;
    logic                take_snap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: go_to_sleep, clock_back, sync_wait, resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (sleep_req)  state_d = ST_PARK;
            ST_PARK:     if (!sleep_req) state_d = ST_RESYNC_A;
            ST_RESYNC_A: state_d = ST_RESYNC_B;
            ST_RESYNC_B: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // decode of the current state into actions
    always_comb begin
        run_hit   = 1'b0;
        set_flag  = 1'b0;
        take_snap = 1'b0;
        wake_req  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run_hit   = |(en_vec & (pin_view ^ snap_q));
                set_flag  = run_hit;
                take_snap = 1'b1;
            end
            ST_PARK, ST_RESYNC_A: begin
                wake_req = |(en_vec & (pin_raw ^ snap_q));
            end
            ST_RESYNC_B: begin
                wake_req  = |(en_vec & (pin_raw ^ snap_q));
                set_flag  = wake_seen;
                take_snap = 1'b1;
            end
            default: begin
                take_snap = 1'b1;
            end
        endcase
    end

    // registered outputs: snapshot and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (take_snap) begin
                snap_q <= pin_view;
            end
            if (set_flag) begin
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign irq     = flag_q;
    assign state_o = state_q;

endmodule

// File: rtl/cos_wake_detector.sv
module cos_wake_detector #(
    parameter int NUM_PINS    = 30,
    parameter int REG_W       = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_dir,
    output logic                irq,
    output logic                wake_req,
    output logic [NUM_PINS-1:0] pullup_en
);

    logic [NUM_PINS-1:0]  en_vec;
    logic [NUM_PINS-1:0]  pin_view;
    logic                 clr_flag;
    logic                 wake_seen;
    cos_pkg::cos_state_e  fsm_state;

    cos_regfile #(
        .NUM_PINS (NUM_PINS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_dir   (pin_dir),
        .en_vec    (en_vec),
        .pullup_en (pullup_en),
        .clr_flag  (clr_flag)
    );

    cos_sync_chain #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_view)
    );

    cos_sync_chain #(
        .W      (1),
        .STAGES (SYNC_STAGES)
    ) u_wake_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_req),
        .q     (wake_seen)
    );

    cos_ctrl #(
        .NUM_PINS (NUM_PINS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .pin_raw   (pin_in),
        .pin_view  (pin_view),
        .en_vec    (en_vec),
        .clr_flag  (clr_flag),
        .wake_seen (wake_seen),
        .irq       (irq),
        .wake_req  (wake_req),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/cos_wake_checker.sv
module cos_wake_checker
    import cos_pkg::*;
#(
    parameter int NUM_PINS = 30,
    parameter int ADDR_W   = 3,
    parameter int CLR_ADDR = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sleep_req,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] pin_dir,
    input logic [NUM_PINS-1:0] pullup_en,
    input logic                irq,
    input logic                wake_req,
    input cos_state_e          fsm_state
);

    // R6
    pullup_off_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_en & pin_dir) == '0);

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == ADDR_W'(CLR_ADDR))) |=> irq);

    // R8
    wake_quiet_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RUN) |-> !wake_req);

    // R7
    park_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PARK && !irq) |=> !irq);

    // R9
    resume_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PARK && !sleep_req) |=> (fsm_state == ST_RESYNC_A));

    // R9
    resume_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RESYNC_A) |=> (fsm_state == ST_RESYNC_B));

endmodule

bind cos_wake_detector cos_wake_checker #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .CLR_ADDR (2 * ((NUM_PINS + REG_W - 1) / REG_W))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .pin_dir   (pin_dir),
    .pullup_en (pullup_en),
    .irq       (irq),
    .wake_req  (wake_req),
    .fsm_state (fsm_state)
);

// File: tb/cos_wake_detector_test.sv
module cos_wake_detector_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [15:0]   bus_wdata = 16'd0;
    logic [15:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_dir = '0;
    logic [NP-1:0] pullup_en;
    logic          irq;
    logic          wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_wake_detector uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_dir   (pin_dir),
        .irq       (irq),
        .wake_req  (wake_req),
        .pullup_en (pullup_en)
    );

    // behavioural reference: pins seen one and two edges back, wake history
    logic [NP-1:0] m_en, m_pu, m_snap, m_p1, m_p2;
    logic          m_w1, m_w2, m_irq;
    int            m_mode;   // 0 awake, 1 parked, 2 and 3 resume steps

    function automatic logic m_wake();
        return (m_mode != 0) && ((m_en & (pin_in ^ m_snap)) != '0);
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_en[15:0];
            3'd1: return {2'b00, m_en[29:16]};
            3'd2: return m_pu[15:0];
            3'd3: return {2'b00, m_pu[29:16]};
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = '0; m_pu = '0; m_snap = '0; m_p1 = '0; m_p2 = '0;
            m_w1 = 1'b0; m_w2 = 1'b0; m_irq = 1'b0; m_mode = 0;
        end else begin : step_model
            logic hit, wk;
            int   nxt;
            wk  = m_wake();
            hit = ((m_mode == 0) && ((m_en & (m_p2 ^ m_snap)) != '0))
                  || ((m_mode == 3) && m_w2);
            if (hit) m_irq = 1'b1;
            else if (bus_wr && bus_addr == 3'd4) m_irq = 1'b0;
            if (m_mode == 0 || m_mode == 3) m_snap = m_p2;
            m_w2 = m_w1; m_w1 = wk;
            m_p2 = m_p1; m_p1 = pin_in;
            case (m_mode)
                0: nxt = sleep_req ? 1 : 0;
                1: nxt = sleep_req ? 1 : 2;
                2: nxt = 3;
                default: nxt = 0;
            endcase
            m_mode = nxt;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_en[15:0]  = bus_wdata;
                    3'd1: m_en[29:16] = bus_wdata[13:0];
                    3'd2: m_pu[15:0]  = bus_wdata;
                    3'd3: m_pu[29:16] = bus_wdata[13:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_val("R3 irq vs model", 32'(irq), 32'(m_irq));
            check_val("R8 wake_req vs model", 32'(wake_req), 32'(m_wake()));
            check_val("R6 pullup_en vs model", 32'(pullup_en), 32'(m_pu & ~pin_dir));
            check_val("R2 rdata vs model", 32'(bus_rdata), 32'(m_read(bus_addr)));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [2:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check_val(tag, 32'(bus_rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check_val("R1 irq after reset", 32'(irq), 32'd0);
        check_val("R1 wake_req after reset", 32'(wake_req), 32'd0);
        check_val("R1 pullup_en after reset", 32'(pullup_en), 32'd0);
        for (int a = 0; a < 4; a++) read_check("R1 register after reset", 3'(a), 16'h0000);

        // R2 layout and unused bits
        step();
        bus_write(3'd1, 16'hFFFF);
        read_check("R2 enable high word masks bits 14-15", 3'd1, 16'h3FFF);
        bus_write(3'd1, 16'h0000);
        bus_write(3'd0, 16'h000F);
        read_check("R2 enable low word", 3'd0, 16'h000F);
        bus_write(3'd3, 16'hA5A5);
        read_check("R2 pull-up high word masks bits 14-15", 3'd3, 16'h25A5);
        bus_write(3'd2, 16'h00FF);
        read_check("R2 unmapped address reads zero", 3'd6, 16'h0000);

        // R6 direction gating
        pin_dir = 30'h0001_000F;
        #1;
        check_val("R6 pull-ups gated by direction", 32'(pullup_en),
                  32'({14'h25A5, 16'h00FF} & ~30'h0001_000F));

        // R4 disabled pins
        repeat (3) step();
        pin_in[20] = ~pin_in[20];
        pin_in[5]  = ~pin_in[5];
        repeat (5) step();
        check_val("R4 disabled pins leave irq low", 32'(irq), 32'd0);

        // R3 latency of an enabled change
        pin_in[2] = ~pin_in[2];
        step();
        check_val("R3 no irq after first edge", 32'(irq), 32'd0);
        step();
        check_val("R3 no irq after second edge", 32'(irq), 32'd0);
        step();
        check_val("R3 irq after third edge", 32'(irq), 32'd1);

        // R5 sticky and clear
        repeat (4) step();
        check_val("R5 irq held", 32'(irq), 32'd1);
        bus_write(3'd4, 16'h1234);
        check_val("R5 irq cleared by write", 32'(irq), 32'd0);
        pin_in[1] = ~pin_in[1];
        step();
        step();
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0000;
        step();
        bus_wr = 1'b0;
        check_val("R5 detection wins over same-edge clear", 32'(irq), 32'd1);
        bus_write(3'd4, 16'h0000);
        check_val("R5 cleared again", 32'(irq), 32'd0);

        // R7 / R8 parking and asynchronous wake
        repeat (3) step();
        sleep_req = 1'b1;
        step();
        check_val("R8 no wake while pins still", 32'(wake_req), 32'd0);
        pin_in[25] = ~pin_in[25];
        #1;
        check_val("R8 disabled pin gives no wake", 32'(wake_req), 32'd0);
        pin_in[3] = ~pin_in[3];
        #1;
        check_val("R8 wake without clock edge", 32'(wake_req), 32'd1);
        repeat (5) step();
        check_val("R7 no irq while parked", 32'(irq), 32'd0);
        check_val("R7 snapshot frozen keeps wake", 32'(wake_req), 32'd1);

        // R9 resume sequence
        sleep_req = 1'b0;
        step();
        step();
        check_val("R9 irq still low in second resume step", 32'(irq), 32'd0);
        step();
        check_val("R9 irq set on leaving resume", 32'(irq), 32'd1);
        check_val("R8 wake low back in run", 32'(wake_req), 32'd0);
        bus_write(3'd4, 16'h0000);
        repeat (5) step();
        check_val("R9 change not reported twice", 32'(irq), 32'd0);

        // R9 reverted change during sleep
        sleep_req = 1'b1;
        step();
        step();
        pin_in[0] = ~pin_in[0];
        #1;
        check_val("R8 wake on pin 0", 32'(wake_req), 32'd1);
        pin_in[0] = ~pin_in[0];
        #1;
        check_val("R8 wake drops on revert", 32'(wake_req), 32'd0);
        sleep_req = 1'b0;
        repeat (5) step();
        check_val("R9 reverted change not reported", 32'(irq), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (R1-R9 run) actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule